// File: doc/BRIEF.md
# Banked Clock Divider Output Stage

This block turns a fast oscillator clock into two derived clocks, one at half and one at a quarter of the oscillator rate. Both come from plain flip-flops, so each has an exact 50% duty cycle whatever the duty cycle of the oscillator. The block drives a 12-bit clock bus arranged as four banks of three outputs. One bank always carries the half-rate clock, so a feedback tap is always available. A two-bit select code decides which derived clock each of the other three banks carries.

An active-low enable holds every output low while it is high. The enable passes through a two-flop synchronizer in the oscillator domain. When the synchronized enable falls, the quarter-rate divider is cleared, so that divider restarts in a known phase against the half-rate clock. A change of select is held back until the edge at which both derived clocks return low, so a bank never shows a shortened pulse. A test input bypasses the dividers and routes a separate reference clock straight to all twelve outputs.

Top module: `clkdiv_bank_top`

## Requirements
- R1: While `rst` is high, every bit of `clkOut` is 0 and the outputs stay disabled until the enable has been synchronized.
- R2: With `testMode` low and the outputs enabled, bits 2:0 carry the half-rate clock, which changes level on every rising edge of `oscClk`: a period of 2 cycles, high for 1.
- R3: The quarter-rate clock has a period of 4 `oscClk` cycles and is high for 2 of them. Each of its rising edges falls on every second rising edge of the half-rate clock.
- R4: Configurable bank k (k = 1, 2, 3) drives bits 3k+2:3k. It carries the quarter-rate clock when the applied select value is greater than k-1, and the half-rate clock otherwise. So 00 gives none, 01 gives bank 1, 10 gives banks 1 and 2, and 11 gives all three.
- R5: `outEnN` is sampled by two flops clocked on `oscClk`. A level applied before a rising edge reaches the gate after the second rising edge. While the gate is closed, all twelve outputs are 0.
- R6: At the edge where the synchronized enable goes from high to low, the quarter-rate clock is cleared to 0. The half-rate clock keeps toggling, so the next quarter-rate rising edge coincides with a half-rate rising edge.
- R7: A new `bankSel` value is taken over only at an edge after which both derived clocks are low. Until then the previous code stays in force.
- R8: While `testMode` is high and the outputs are enabled, all twelve outputs follow `refClk` directly. While the outputs are disabled, they stay 0.
- R9: After reset both derived clocks are 0, and the first rising edge of `oscClk` after reset takes both of them high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| oscClk | input | 1 | Fast oscillator clock that feeds the dividers |
| refClk | input | 1 | Reference clock routed to the outputs in test mode |
| rst | input | 1 | Asynchronous active-high reset |
| testMode | input | 1 | 1 = bypass the dividers and route refClk to the outputs |
| outEnN | input | 1 | Active-low output enable |
| bankSel | input | 2 | Code that picks the configurable banks carrying the quarter-rate clock |
| clkOut | output | 12 | Clock outputs, four banks of three; bits 2:0 are the fixed bank |

## Verification
The bench steps through all four select codes. Some codes change mid-phase, which separates taking a new code at once from holding it until both clocks are low. The enable is dropped at several divider phases, which shows that the quarter-rate clock is realigned and not left free-running. The enable is also raised and held, which exercises the all-low gating and the two-cycle synchronizer delay. In test mode the bench samples both levels of the reference clock, and a mid-run reset confirms that both clocks restart low and rise together on the first edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // Number of banks whose source can be chosen by the select code.
  localparam int CFG_BANKS = 3;

  // Strobes handed from the control module to the datapath.
  typedef struct packed {
    logic                 gateOn;   // outputs allowed to toggle
    logic                 clrDiv4;  // clear quarter-rate divider at this edge
    logic [CFG_BANKS-1:0] bankMask; // 1 = bank carries quarter-rate clock
  } ctrl_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 2
) (
  input  logic             oscClk,
  input  logic             rst,
  input  logic             outEnN,
  input  logic [SEL_W-1:0] bankSel,
  input  logic             div2Now,
  input  logic             div4Now,
  output ctrl_t            strobes
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0]       syncReg;
  logic [SEL_W-1:0]   selReg;
  logic               fallNext;
  logic               bothLowNext;
  logic [CFG_BANKS-1:0] maskVec;

  // Enable synchronizer; reset to the disabled level.
  always_ff @(posedge oscClk or posedge rst) begin
    if (rst) syncReg <= '1;
    else     syncReg <= {syncReg[TOP-1:0], outEnN};
  end

  // Synchronized enable about to go from high to low at this edge.
  assign fallNext = syncReg[TOP] & ~syncReg[TOP-1];

  // After this edge both derived clocks will be low.
  assign bothLowNext = div2Now & (fallNext | ~div4Now);

  always_ff @(posedge oscClk or posedge rst) begin
    if (rst)              selReg <= '0;
    else if (bothLowNext) selReg <= bankSel;
  end

  // Thermometer decode: bank k+1 takes quarter rate when code > k.
  for (genvar k = 0; k < CFG_BANKS; k++) begin : g_mask
    assign maskVec[k] = (32'(selReg) > k);
  end

  assign strobes.gateOn   = ~syncReg[TOP];
  assign strobes.clrDiv4  = fallNext;
  assign strobes.bankMask = maskVec;
endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
#(
  parameter int BANK_SIZE = 3,
  parameter int NUM_BANKS = CFG_BANKS + 1,
  localparam int OUT_W    = NUM_BANKS * BANK_SIZE
) (
  input  logic             oscClk,
  input  logic             rst,
  input  logic             refClk,
  input  logic             testMode,
  input  ctrl_t            strobes,
  output logic             div2Now,
  output logic             div4Now,
  output logic [OUT_W-1:0] clkOut
);
  logic div2Q;
  logic div4Q;

  // Half-rate flop toggles every edge; quarter-rate flop toggles on
  // the edges where the half-rate flop rises.
  always_ff @(posedge oscClk or posedge rst) begin
    if (rst) begin
      div2Q <= 1'b0;
      div4Q <= 1'b0;
    end else begin
      div2Q <= ~div2Q;
      if (strobes.clrDiv4) div4Q <= 1'b0;
      else if (!div2Q)     div4Q <= ~div4Q;
    end
  end

  assign div2Now = div2Q;
  assign div4Now = div4Q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic srcClk;
    logic outBit;
    if (b == 0) begin : g_fixed
      assign srcClk = div2Q;
    end else begin : g_cfg
      assign srcClk = strobes.bankMask[b-1] ? div4Q : div2Q;
    end
    assign outBit = strobes.gateOn & (testMode ? refClk : srcClk);
    assign clkOut[b*BANK_SIZE +: BANK_SIZE] = {BANK_SIZE{outBit}};
  end
endmodule

// File: rtl/clkdiv_bank_top.sv
module clkdiv_bank_top
  import clkdiv_pkg::*;
#(
  parameter int BANK_SIZE   = 3,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_BANKS  = CFG_BANKS + 1,
  localparam int OUT_W      = NUM_BANKS * BANK_SIZE
) (
  input  logic             oscClk,
  input  logic             refClk,
  input  logic             rst,
  input  logic             testMode,
  input  logic             outEnN,
  input  logic [1:0]       bankSel,
  output logic [OUT_W-1:0] clkOut
);
  ctrl_t strobes;
  logic  div2Now;
  logic  div4Now;

  clkdiv_ctrl #(.SYNC_STAGES(SYNC_STAGES), .SEL_W(2)) u_ctrl (
    .oscClk (oscClk),
    .rst    (rst),
    .outEnN (outEnN),
    .bankSel(bankSel),
    .div2Now(div2Now),
    .div4Now(div4Now),
    .strobes(strobes)
  );

  clkdiv_datapath #(.BANK_SIZE(BANK_SIZE), .NUM_BANKS(NUM_BANKS)) u_dp (
    .oscClk  (oscClk),
    .rst     (rst),
    .refClk  (refClk),
    .testMode(testMode),
    .strobes (strobes),
    .div2Now (div2Now),
    .div4Now (div4Now),
    .clkOut  (clkOut)
  );
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk
  import clkdiv_pkg::*;
#(
  parameter int OUT_W = 12
) (
  input logic             oscClk,
  input logic             rst,
  input logic [OUT_W-1:0] clkOut,
  input logic             div2Now,
  input logic             div4Now,
  input ctrl_t            strobes
);
  // R2: half-rate clock changes level on every edge
  assert_div2_toggle_R2: assert property (@(posedge oscClk) disable iff (rst)
    1'b1 |=> (div2Now != $past(div2Now)));

  // R3: quarter-rate rising edge only together with half-rate rising edge
  assert_div4_align_R3: assert property (@(posedge oscClk) disable iff (rst)
    $rose(div4Now) |-> $rose(div2Now));

  // R5: closed gate means all outputs low
  assert_gate_low_R5: assert property (@(posedge oscClk) disable iff (rst)
    !strobes.gateOn |-> (clkOut == '0));

  // R6: enable fall clears the quarter-rate clock
  assert_clr_div4_R6: assert property (@(posedge oscClk) disable iff (rst)
    strobes.clrDiv4 |=> !div4Now);

  // R7: bank selection only changes where both derived clocks are low
  assert_sel_handoff_R7: assert property (@(posedge oscClk) disable iff (rst)
    !$stable(strobes.bankMask) |-> (!div2Now && !div4Now));
endmodule

bind clkdiv_bank_top clkdiv_bank_chk #(.OUT_W(OUT_W)) u_chk (
  .oscClk (oscClk),
  .rst    (rst),
  .clkOut (clkOut),
  .div2Now(div2Now),
  .div4Now(div4Now),
  .strobes(strobes)
);

// File: tb/sim_clkdiv_bank_top.sv
`timescale 1ns/1ps
module sim_clkdiv_bank_top;
  logic        oscClk = 1'b0;
  logic        refClk = 1'b0;
  logic        rst = 1'b1;
  logic        testMode = 1'b0;
  logic        outEnN = 1'b1;
  logic [1:0]  bankSel = 2'b00;
  logic [11:0] clkOut;

  int    checks = 0;
  int    fails = 0;
  int    cycles = 0;
  string curTag = "R5";

  logic [11:0] expQ[$];

  // Bench-side model state (requirement level)
  int         mPhase = 0;   // 0:both low 1:both high 2:q high 3:h high
  logic       mQ1 = 1'b1;
  logic       mQ2 = 1'b1;
  logic [1:0] mSel = 2'b00;

  always #2 oscClk = ~oscClk;   // 250 MHz
  always #7 refClk = ~refClk;

  clkdiv_bank_top u0 (
    .oscClk(oscClk), .refClk(refClk), .rst(rst), .testMode(testMode),
    .outEnN(outEnN), .bankSel(bankSel), .clkOut(clkOut)
  );

  function automatic logic [11:0] expWord(int ph, logic [1:0] sel, logic gate);
    logic h, q;
    logic [11:0] w;
    h = (ph == 1) || (ph == 3);
    q = (ph == 1) || (ph == 2);
    w[2:0] = {3{h}};
    for (int k = 1; k <= 3; k++) begin
      w[3*k +: 3] = (int'(sel) > k - 1) ? {3{q}} : {3{h}};
    end
    return gate ? w : 12'h000;
  endfunction

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: predicts each cycle's output and pushes it to the scoreboard.
  task automatic predict();
    logic newQ2, fall, h;
    int   nextPh;
    newQ2  = mQ1;
    fall   = mQ2 && !newQ2;
    h      = (mPhase == 1) || (mPhase == 3);
    nextPh = fall ? (h ? 0 : 3) : (mPhase + 1) % 4;
    if (nextPh == 0) mSel = bankSel;
    mQ2 = newQ2;
    mQ1 = outEnN;
    mPhase = nextPh;
    if (!testMode) expQ.push_back(expWord(mPhase, mSel, !mQ2));
  endtask

  always @(posedge oscClk or posedge rst) begin
    if (rst) begin
      mPhase = 0; mQ1 = 1'b1; mQ2 = 1'b1; mSel = 2'b00;
      expQ.delete();
    end else begin
      predict();
    end
  end

  // Monitor: pops and compares away from the active edge.
  always @(negedge oscClk) begin
    if (!rst && expQ.size() > 0) begin
      logic [11:0] e;
      e = expQ.pop_front();
      check(curTag, clkOut, e);
    end
  end

  task automatic waitCyc(int n);
    for (int i = 0; i < n; i++) @(negedge oscClk);
    #1;
  endtask

  // Watchdog
  always @(posedge oscClk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1 reset outputs low", clkOut, 12'h000);
    waitCyc(2);
    check("R1 held in reset", clkOut, 12'h000);
    rst = 1'b0;
    curTag = "R5 disabled after reset";
    waitCyc(5);
    outEnN = 1'b0; curTag = "R9/R2 first run, select 00";
    waitCyc(20);
    bankSel = 2'b01; curTag = "R4/R7 select 01";
    waitCyc(1);
    bankSel = 2'b01;
    waitCyc(16);
    bankSel = 2'b10; curTag = "R4/R7 select 10 mid-phase";
    waitCyc(15);
    bankSel = 2'b11; curTag = "R3/R4 select 11";
    waitCyc(18);
    outEnN = 1'b1; curTag = "R5 disable latency";
    waitCyc(9);
    outEnN = 1'b0; curTag = "R6 realign after enable fall A";
    waitCyc(13);
    outEnN = 1'b1; curTag = "R5 disable again";
    waitCyc(6);
    outEnN = 1'b0; curTag = "R6 realign after enable fall B";
    waitCyc(14);
    bankSel = 2'b00; curTag = "R7 select back to 00";
    waitCyc(2);
    bankSel = 2'b10;
    waitCyc(12);
    // Test mode bypass
    testMode = 1'b1; curTag = "R8";
    waitCyc(2);
    for (int i = 0; i < 3; i++) begin
      @(posedge refClk); #1;
      check("R8 bypass follows refClk high", clkOut, 12'hfff);
      @(negedge refClk); #1;
      check("R8 bypass follows refClk low", clkOut, 12'h000);
    end
    outEnN = 1'b1;
    waitCyc(3);
    @(posedge refClk); #1;
    check("R8/R5 bypass gated off", clkOut, 12'h000);
    outEnN = 1'b0;
    waitCyc(3);
    testMode = 1'b0; curTag = "R2/R3 after bypass";
    waitCyc(12);
    // Mid-run reset
    rst = 1'b1;
    #1;
    check("R1 async reset mid-run", clkOut, 12'h000);
    waitCyc(2);
    bankSel = 2'b11;
    rst = 1'b0; curTag = "R9 restart after reset";
    waitCyc(20);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule